// File: doc/BRIEF.md
# Latch-Bank Output Expander

This block turns a handful of chip pins into a much larger set of output-only lines. It drives a bank of external latches whose data inputs all hang on one shared parallel bus, while each latch has a clock line of its own. A bank of `NUM_LATCH` latches, each `BUS_W` bits wide, gives `NUM_LATCH*BUS_W` virtual outputs from `NUM_LATCH+BUS_W` pins.

The host asks for one bit at a time, giving an output index and a value over a valid/ready handshake. The block keeps a shadow word for every latch. For each request it changes only the addressed bit of the right shadow word. It places that latch's whole updated word on the shared bus, holds it there for a set number of cycles, and then pulses only that latch's clock line high for a set number of cycles. The handshake stays busy until the pulse has ended, so requests are handled one after another. An index past the last output is taken and then dropped, and it raises a sticky error flag.

Top module: `outExpander`

## Requirements
- R1: After reset, busData and latchClk are all zero, errFlag is 0, reqReady is 1, and every shadow word is zero. So the first write to any latch puts a word on the bus in which only the written bit can be 1.
- R2: Index i addresses latch number i / BUS_W and bit i % BUS_W of that latch. Latch k is strobed on latchClk bit k, and bit b of the word is carried on busData bit b.
- R3: An accepted write changes only the addressed bit of its latch's shadow word. The word placed on busData is the full shadow word after that change, and it includes every bit written earlier to that latch.
- R4: The updated word appears on busData on the clock edge that accepts the request. It then stays stable for exactly SETUP_CYC cycles before the selected clock line rises, and it stays stable while that line is high.
- R5: A strobe holds exactly one latchClk bit high, the one for the addressed latch, for exactly PULSE_CYC cycles and then drives it low. All other clock lines stay low, and no two lines are ever high together.
- R6: reqReady is low from the cycle after acceptance until the strobe has returned low. It is high again in the first cycle in which latchClk is all zero after the strobe.
- R7: A request with index at or beyond NUM_LATCH*BUS_W is accepted and ignored: busData, latchClk and all shadow words are unchanged, and reqReady stays high. It sets errFlag, and errFlag stays 1 until reset.
- R8: lineIsOutput reports every virtual line as an output (all bits 1) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqIndex | input | IDX_W = $clog2(NUM_LATCH*BUS_W)+1 | Virtual output index |
| reqValue | input | 1 | Value for the addressed output |
| busData | output | BUS_W | Shared data bus to all latches |
| latchClk | output | NUM_LATCH | One clock line per latch |
| errFlag | output | 1 | Sticky flag for out-of-range requests |
| lineIsOutput | output | NUM_LATCH*BUS_W | Direction of each virtual line (1 = output) |

## Verification
The assertions assume that reqIndex and reqValue stay steady while reqValid is high in the accepting cycle. They also assume that reset is held long enough to clear the shadow words before the first request. The stimulus keeps to this by driving a request only at the falling clock edge while reqReady is high, and by dropping reqValid right after the accepting edge. The random indices run a few steps past the last output, so the ignored-request path gets exercised between normal writes.

// File: rtl/outExpPkg.sv
package outExpPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic load;    // accept a valid request, update shadow and bus
    logic reject;  // accept an out-of-range request, flag only
    logic rise;    // raise the selected latch clock
    logic fall;    // drop the latch clock
  } strobe_t;
endpackage

// File: rtl/outExpCtrl.sv
module outExpCtrl
  import outExpPkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    idxOk,
  output logic    reqReady,
  output strobe_t stb
);
  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stb      = '0;
    reqReady = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (idxOk) stb.load = 1'b1;
          else       stb.reject = 1'b1;
        end
      end
      ST_SETUP: if (cnt == SETUP_LAST) stb.rise = 1'b1;
      ST_PULSE: if (cnt == PULSE_LAST) stb.fall = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (stb.load) begin
            state <= ST_SETUP;
            cnt   <= '0;
          end
        end
        ST_SETUP: begin
          if (stb.rise) begin
            state <= ST_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PULSE: begin
          if (stb.fall) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/outExpData.sv
module outExpData
  import outExpPkg::*;
#(
  parameter int NUM_LATCH = 2,
  parameter int BUS_W     = 8,
  localparam int TOTAL    = NUM_LATCH * BUS_W,
  localparam int IDX_W    = $clog2(TOTAL) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [IDX_W-1:0]     reqIndex,
  input  logic                 reqValue,
  output logic                 idxOk,
  output logic [BUS_W-1:0]     busData,
  output logic [NUM_LATCH-1:0] latchClk,
  output logic                 errFlag
);
  localparam int BIT_W = (BUS_W > 1) ? $clog2(BUS_W) : 1;

  logic [BUS_W-1:0]     shadow [NUM_LATCH];
  logic [IDX_W-1:0]     reqLatch;
  logic [BIT_W-1:0]     reqBit;
  logic [NUM_LATCH-1:0] latchHit;
  logic [NUM_LATCH-1:0] armSel;
  logic [BUS_W-1:0]     curWord;
  logic [BUS_W-1:0]     newWord;

  assign idxOk    = (reqIndex < IDX_W'(TOTAL));
  assign reqLatch = IDX_W'(reqIndex / IDX_W'(BUS_W));
  assign reqBit   = BIT_W'(reqIndex % IDX_W'(BUS_W));

  for (genvar l = 0; l < NUM_LATCH; l++) begin : gHit
    assign latchHit[l] = (reqLatch == IDX_W'(l));
  end

  always_comb begin
    curWord = '0;
    for (int l = 0; l < NUM_LATCH; l++) begin
      if (latchHit[l]) curWord = shadow[l];
    end
    newWord         = curWord;
    newWord[reqBit] = reqValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LATCH; l++) shadow[l] <= '0;
      armSel  <= '0;
      busData <= '0;
    end else if (stb.load) begin
      for (int l = 0; l < NUM_LATCH; l++) begin
        if (latchHit[l]) shadow[l] <= newWord;
      end
      armSel  <= latchHit;
      busData <= newWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         latchClk <= '0;
    else if (stb.rise) latchClk <= armSel;
    else if (stb.fall) latchClk <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           errFlag <= 1'b0;
    else if (stb.reject) errFlag <= 1'b1;
  end
endmodule

// File: rtl/outExpander.sv
module outExpander
  import outExpPkg::*;
#(
  parameter int NUM_LATCH = 2,
  parameter int BUS_W     = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  localparam int TOTAL    = NUM_LATCH * BUS_W,
  localparam int IDX_W    = $clog2(TOTAL) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [IDX_W-1:0]     reqIndex,
  input  logic                 reqValue,
  output logic [BUS_W-1:0]     busData,
  output logic [NUM_LATCH-1:0] latchClk,
  output logic                 errFlag,
  output logic [TOTAL-1:0]     lineIsOutput
);
  strobe_t stb;
  logic    idxOk;

  assign lineIsOutput = '1;

  outExpCtrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .idxOk    (idxOk),
    .reqReady (reqReady),
    .stb      (stb)
  );

  outExpData #(
    .NUM_LATCH(NUM_LATCH),
    .BUS_W    (BUS_W)
  ) dataI (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqIndex (reqIndex),
    .reqValue (reqValue),
    .idxOk    (idxOk),
    .busData  (busData),
    .latchClk (latchClk),
    .errFlag  (errFlag)
  );
endmodule

// File: rtl/outExpander_chk.sv
module outExpander_chk #(
  parameter int NUM_LATCH = 2,
  parameter int BUS_W     = 8,
  localparam int TOTAL    = NUM_LATCH * BUS_W,
  localparam int IDX_W    = $clog2(TOTAL) + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [IDX_W-1:0]     reqIndex,
  input logic [BUS_W-1:0]     busData,
  input logic [NUM_LATCH-1:0] latchClk,
  input logic                 errFlag
);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(latchClk));

  // R4
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|latchClk) |-> $stable(busData));

  // R6
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|latchClk) |-> !reqReady);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R7
  bad_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqIndex >= IDX_W'(TOTAL)))
      |=> ($stable(busData) && errFlag && reqReady && (latchClk == '0)));
endmodule

bind outExpander outExpander_chk #(
  .NUM_LATCH(NUM_LATCH),
  .BUS_W    (BUS_W)
) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqIndex (reqIndex),
  .busData  (busData),
  .latchClk (latchClk),
  .errFlag  (errFlag)
);

// File: tb/outExpander_test.sv
`timescale 1ns/1ps
module outExpander_test;
  localparam int NUM_LATCH = 2;
  localparam int BUS_W     = 8;
  localparam int SETUP_CYC = 2;
  localparam int PULSE_CYC = 2;
  localparam int TOTAL     = NUM_LATCH * BUS_W;
  localparam int IDX_W     = $clog2(TOTAL) + 1;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 reqValid;
  logic                 reqReady;
  logic [IDX_W-1:0]     reqIndex;
  logic                 reqValue;
  logic [BUS_W-1:0]     busData;
  logic [NUM_LATCH-1:0] latchClk;
  logic                 errFlag;
  logic [TOTAL-1:0]     lineIsOutput;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [BUS_W-1:0] model [NUM_LATCH];
  logic [BUS_W-1:0] lastBus;
  bit               expErr;

  always #2 clk = ~clk;

  outExpander #(
    .NUM_LATCH(NUM_LATCH), .BUS_W(BUS_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIndex(reqIndex), .reqValue(reqValue), .busData(busData),
    .latchClk(latchClk), .errFlag(errFlag), .lineIsOutput(lineIsOutput)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] applyBit(logic [BUS_W-1:0] w, int b, bit v);
    logic [BUS_W-1:0] r = w;
    r[b] = v;
    return r;
  endfunction

  task automatic doWrite(int idx, bit val);
    int n = 0;
    int p = 0;
    int readyHigh = 0;
    int latch = idx / BUS_W;
    int bitPos = idx % BUS_W;
    bit good = (idx < TOTAL);
    check("R6 ready before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqIndex = IDX_W'(idx);
    reqValue = val;
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);
    if (good) begin
      model[latch] = applyBit(model[latch], bitPos, val);
      check("R4 bus at accept", longint'(busData), longint'(model[latch]));
      while (latchClk == '0 && n < 50) begin
        n++;
        if (reqReady) readyHigh++;
        @(negedge clk);
      end
      check("R4 setup cycles", n, SETUP_CYC);
      check("R2 strobe line", longint'(latchClk), longint'(1) << latch);
      check("R3 full shadow word", longint'(busData), longint'(model[latch]));
      while (latchClk != '0 && p < 50) begin
        p++;
        if (reqReady) readyHigh++;
        @(negedge clk);
      end
      check("R5 pulse cycles", p, PULSE_CYC);
      check("R6 ready low while busy", readyHigh, 0);
      check("R6 ready after strobe", int'(reqReady), 1);
      lastBus = model[latch];
    end else begin
      expErr = 1'b1;
      check("R7 bus unchanged", longint'(busData), longint'(lastBus));
      check("R7 no strobe", longint'(latchClk), 0);
      check("R7 ready stays high", int'(reqReady), 1);
      check("R7 error flag", int'(errFlag), 1);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd12345));
    for (int l = 0; l < NUM_LATCH; l++) model[l] = '0;
    lastBus  = '0;
    expErr   = 1'b0;
    rstN     = 1'b0;
    reqValid = 1'b0;
    reqIndex = '0;
    reqValue = 1'b0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bus reset", longint'(busData), 0);
    check("R1 clocks reset", longint'(latchClk), 0);
    check("R1 error reset", int'(errFlag), 0);
    check("R1 ready reset", int'(reqReady), 1);
    // R8 direction query
    check("R8 all outputs", longint'(lineIsOutput), longint'({TOTAL{1'b1}}));

    // directed corners: R2 mapping, R3 read-modify-write
    doWrite(3, 1'b1);
    check("R1 zero shadow first write", longint'(busData), 64'h08);
    doWrite(0, 1'b1);
    doWrite(BUS_W, 1'b1);
    doWrite(TOTAL - 1, 1'b1);
    doWrite(3, 1'b0);
    check("R3 bit cleared others kept", longint'(busData), 64'h01);
    // R7 out-of-range, smallest and largest
    doWrite(TOTAL, 1'b1);
    doWrite((1 << IDX_W) - 1, 1'b1);
    doWrite(BUS_W + 1, 1'b1);
    check("R3 latch1 shadow after ignored", longint'(busData), 64'h83);

    for (int k = 0; k < 60; k++) begin
      doWrite(int'($urandom_range(TOTAL + 3, 0)), bit'($urandom_range(1, 0)));
      check("R7 sticky flag", int'(errFlag), int'(expErr));
    end
    check("R8 all outputs end", longint'(lineIsOutput), longint'({TOTAL{1'b1}}));
    finishRun();
  end
endmodule